// File: doc/BRIEF.md
# Speculative Load Fill Buffer

This block is a small, fully associative side buffer placed next to an L1 data cache. Lines fetched on behalf of loads that are still speculative are parked here instead of in the L1. The L1 only sees a line once the load that brought it in has retired. A retired load's line is handed to the L1 through an explicit install request. A load that is squashed simply loses its entry, and nothing reaches the L1.

Every accepted load issue gets one entry, which is identified by the load's tag. In the cycle after issue, the buffer reports one of two results. On a hit, the same line is already resident and filled in another entry, and the data comes back without a request to the next level. On a miss, a line request goes to the next level, and the fill later lands in the entry that carries the matching tag. Two loads to the same line each get their own entry. The reorder logic sends commit and squash events by tag. When all entries are in use, the issue interface stalls.

Top module: `spec_fill_buffer`

## Requirements
- R1: After reset all entries are free, `iss_ready` is 1, and `resp_valid`, `mem_req_valid` and `ins_valid` are 0.
- R2: An issue is accepted in a cycle where `iss_valid` and `iss_ready` are both 1. Each accepted issue gives exactly one `resp_valid` pulse in the next cycle, carrying the issuing tag. On a miss (`resp_hit`=0), `mem_req_valid` pulses in that same cycle with the same tag and the issue address with its low log2(line bytes) bits cleared.
- R3: An issue hits when some entry holds the same line address (address bits above the 6-bit offset) and has already been filled. In that case `resp_hit`=1, `resp_data` is that line, no next-level request is made, and a new entry, already filled, is still allocated for the issuing tag.
- R4: A fill writes its data only into a live entry with the matching tag that has not been filled yet. A fill for any other tag has no effect, so a later issue to that line still misses.
- R5: `iss_ready` is 0 exactly when all entries are in use, and issues are not accepted while it is 0.
- R6: A commit for a live speculative tag marks that entry commit-pending. Install requests are made only for commit-pending entries that are filled, with `ins_addr` set to the line-aligned address and `ins_data` set to the line.
- R7: Once `ins_valid` is raised, it stays at 1 with `ins_addr` and `ins_data` unchanged until `ins_ready` is 1. The entry is freed on that accepting edge.
- R8: A squash for a live speculative tag frees its entry with no install. A fill or commit that arrives later for that tag is ignored.
- R9: When a commit and a squash name the same tag in the same cycle, the squash wins and that line is never installed.
- R10: The number of accepted installs equals the number of effective commits, and every install corresponds to a committed load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Load issue request |
| iss_ready | output | 1 | An entry is free to accept an issue |
| iss_tag | input | 4 | Tag of the issuing load |
| iss_addr | input | 32 | Load address |
| resp_valid | output | 1 | Lookup result for the issue of the previous cycle |
| resp_hit | output | 1 | Line found filled in the buffer |
| resp_tag | output | 4 | Tag the result belongs to |
| resp_data | output | 512 | Line data on a hit, zero otherwise |
| mem_req_valid | output | 1 | Line request to the next level |
| mem_req_addr | output | 32 | Line-aligned request address |
| mem_req_tag | output | 4 | Tag that the fill must return with |
| fill_valid | input | 1 | Fill from the next level |
| fill_tag | input | 4 | Tag of the fill |
| fill_data | input | 512 | Fill line |
| cmt_valid | input | 1 | Load retirement event |
| cmt_tag | input | 4 | Tag of the retiring load |
| sq_valid | input | 1 | Load squash event |
| sq_tag | input | 4 | Tag of the squashed load |
| ins_valid | output | 1 | Install request toward the L1 |
| ins_ready | input | 1 | L1 accepts the install |
| ins_addr | output | 32 | Line-aligned install address |
| ins_data | output | 512 | Line to install |

## Verification
Several events can land on one clock edge. The main case is a commit and a squash for the same tag in one cycle. Other cases are a squash together with a fill for that tag, and an install acceptance that frees an entry while a new issue hits on its line. The bench drives these collisions both from directed sequences and from dense random traffic. A behavioural tag-indexed model applies squash before commit and fill, and looks up hits against the state that existed before the edge. Every install the design offers must then match a committed, filled load in that model, and after the final drain the install count must equal the count of effective commits.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    typedef struct packed {
        logic valid;
        logic spec;
        logic pend;
        logic filled;
    } ent_flags_t;

    localparam ent_flags_t FLAGS_FREE = '{valid: 1'b0, spec: 1'b0, pend: 1'b0, filled: 1'b0};

    function automatic logic ready_to_install(ent_flags_t f);
        return f.valid && f.pend && f.filled;
    endfunction

    function automatic logic live_spec(ent_flags_t f);
        return f.valid && f.spec;
    endfunction

endpackage

// File: rtl/sfb_pick_first.sv
module sfb_pick_first #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
    assign any = |req;
endmodule

// File: rtl/sfb_line_match.sv
module sfb_line_match #(
    parameter int N_ENT   = 8,
    parameter int LADDR_W = 26
) (
    input  logic [N_ENT-1:0]         valid_vec,
    input  logic [N_ENT-1:0]         filled_vec,
    input  logic [N_ENT*LADDR_W-1:0] lines_flat,
    input  logic [LADDR_W-1:0]       key,
    output logic [N_ENT-1:0]         hit_vec
);
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g] && filled_vec[g]
                            && (lines_flat[g*LADDR_W +: LADDR_W] == key);
    end
endmodule

// File: rtl/sfb_entry.sv
module sfb_entry
    import sfb_pkg::*;
#(
    parameter int TAG_W   = 4,
    parameter int LADDR_W = 26,
    parameter int LINE_W  = 512
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc_en,
    input  logic [TAG_W-1:0]   alloc_tag,
    input  logic [LADDR_W-1:0] alloc_line,
    input  logic               alloc_filled,
    input  logic [LINE_W-1:0]  alloc_data,
    input  logic               fill_valid,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic [LINE_W-1:0]  fill_data,
    input  logic               cmt_valid,
    input  logic [TAG_W-1:0]   cmt_tag,
    input  logic               sq_valid,
    input  logic [TAG_W-1:0]   sq_tag,
    input  logic               free_en,
    output ent_flags_t         flags_o,
    output logic [TAG_W-1:0]   tag_o,
    output logic [LADDR_W-1:0] line_o,
    output logic [LINE_W-1:0]  data_o
);
    logic cmt_hit, sq_hit, fill_hit;

    assign cmt_hit  = live_spec(flags_o) && cmt_valid && (cmt_tag == tag_o);
    assign sq_hit   = live_spec(flags_o) && sq_valid && (sq_tag == tag_o);
    assign fill_hit = flags_o.valid && !flags_o.filled && fill_valid && (fill_tag == tag_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_o <= FLAGS_FREE;
            tag_o   <= '0;
            line_o  <= '0;
        end else if (alloc_en) begin
            flags_o <= '{valid: 1'b1, spec: 1'b1, pend: 1'b0, filled: alloc_filled};
            tag_o   <= alloc_tag;
            line_o  <= alloc_line;
        end else if (sq_hit) begin
            flags_o <= FLAGS_FREE;
        end else if (free_en) begin
            flags_o <= FLAGS_FREE;
        end else begin
            if (cmt_hit) begin
                flags_o.spec <= 1'b0;
                flags_o.pend <= 1'b1;
            end
            if (fill_hit) flags_o.filled <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) begin
            if (alloc_filled) data_o <= alloc_data;
        end else if (fill_hit && !sq_hit) begin
            data_o <= fill_data;
        end
    end
endmodule

// File: rtl/spec_fill_buffer.sv
module spec_fill_buffer
    import sfb_pkg::*;
#(
    parameter int N_ENT      = 8,
    parameter int LINE_BYTES = 64,
    parameter int TAG_W      = 4,
    parameter int ADDR_W     = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    iss_valid,
    output logic                    iss_ready,
    input  logic [TAG_W-1:0]        iss_tag,
    input  logic [ADDR_W-1:0]       iss_addr,
    output logic                    resp_valid,
    output logic                    resp_hit,
    output logic [TAG_W-1:0]        resp_tag,
    output logic [LINE_BYTES*8-1:0] resp_data,
    output logic                    mem_req_valid,
    output logic [ADDR_W-1:0]       mem_req_addr,
    output logic [TAG_W-1:0]        mem_req_tag,
    input  logic                    fill_valid,
    input  logic [TAG_W-1:0]        fill_tag,
    input  logic [LINE_BYTES*8-1:0] fill_data,
    input  logic                    cmt_valid,
    input  logic [TAG_W-1:0]        cmt_tag,
    input  logic                    sq_valid,
    input  logic [TAG_W-1:0]        sq_tag,
    output logic                    ins_valid,
    input  logic                    ins_ready,
    output logic [ADDR_W-1:0]       ins_addr,
    output logic [LINE_BYTES*8-1:0] ins_data
);
    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int LADDR_W = ADDR_W - OFF_W;
    localparam int LINE_W  = LINE_BYTES * 8;
    localparam int IDX_W   = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'(1) << OFF_W) - 1);

    ent_flags_t         flags [N_ENT];
    logic [TAG_W-1:0]   etag  [N_ENT];
    logic [LADDR_W-1:0] eline [N_ENT];
    logic [LINE_W-1:0]  edata [N_ENT];

    logic [N_ENT-1:0] valid_vec, filled_vec, pend_vec, spec_vec, cand_vec, hit_vec;
    logic [N_ENT-1:0] alloc_vec, free_vec;
    logic [N_ENT*LADDR_W-1:0] lines_flat;

    logic               hit_any, free_any, cand_any, accept;
    logic [IDX_W-1:0]   hit_idx, free_idx, cand_idx;
    logic [LADDR_W-1:0] iss_line;
    logic [LINE_W-1:0]  hit_line_data;

    logic             ins_busy;
    logic [IDX_W-1:0] ins_idx;

    // Per-entry status vectors
    for (genvar g = 0; g < N_ENT; g++) begin : g_vec
        assign valid_vec[g]  = flags[g].valid;
        assign filled_vec[g] = flags[g].filled;
        assign pend_vec[g]   = flags[g].pend;
        assign spec_vec[g]   = flags[g].spec;
        assign cand_vec[g]   = ready_to_install(flags[g]);
        assign lines_flat[g*LADDR_W +: LADDR_W] = eline[g];
    end

    assign iss_line = iss_addr[ADDR_W-1:OFF_W];

    sfb_line_match #(.N_ENT(N_ENT), .LADDR_W(LADDR_W)) u_match (
        .valid_vec  (valid_vec),
        .filled_vec (filled_vec),
        .lines_flat (lines_flat),
        .key        (iss_line),
        .hit_vec    (hit_vec)
    );

    sfb_pick_first #(.N(N_ENT), .IDX_W(IDX_W)) u_hit_sel (
        .req (hit_vec), .any (hit_any), .idx (hit_idx)
    );

    sfb_pick_first #(.N(N_ENT), .IDX_W(IDX_W)) u_free_sel (
        .req (~valid_vec), .any (free_any), .idx (free_idx)
    );

    sfb_pick_first #(.N(N_ENT), .IDX_W(IDX_W)) u_ins_sel (
        .req (cand_vec), .any (cand_any), .idx (cand_idx)
    );

    assign iss_ready     = free_any;
    assign accept        = iss_valid && iss_ready;
    assign hit_line_data = edata[hit_idx];

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        assign alloc_vec[g] = accept && (free_idx == IDX_W'(g));
        assign free_vec[g]  = ins_valid && ins_ready && (ins_idx == IDX_W'(g));

        sfb_entry #(.TAG_W(TAG_W), .LADDR_W(LADDR_W), .LINE_W(LINE_W)) u_ent (
            .clk          (clk),
            .rst          (rst),
            .alloc_en     (alloc_vec[g]),
            .alloc_tag    (iss_tag),
            .alloc_line   (iss_line),
            .alloc_filled (hit_any),
            .alloc_data   (hit_line_data),
            .fill_valid   (fill_valid),
            .fill_tag     (fill_tag),
            .fill_data    (fill_data),
            .cmt_valid    (cmt_valid),
            .cmt_tag      (cmt_tag),
            .sq_valid     (sq_valid),
            .sq_tag       (sq_tag),
            .free_en      (free_vec[g]),
            .flags_o      (flags[g]),
            .tag_o        (etag[g]),
            .line_o       (eline[g]),
            .data_o       (edata[g])
        );
    end

    // Lookup result and next-level request, one cycle after issue
    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid    <= 1'b0;
            resp_hit      <= 1'b0;
            resp_tag      <= '0;
            resp_data     <= '0;
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
            mem_req_tag   <= '0;
        end else begin
            resp_valid    <= accept;
            resp_hit      <= accept && hit_any;
            resp_tag      <= iss_tag;
            resp_data     <= (accept && hit_any) ? hit_line_data : '0;
            mem_req_valid <= accept && !hit_any;
            mem_req_addr  <= iss_addr & ~OFF_MASK;
            mem_req_tag   <= iss_tag;
        end
    end

    // Install channel: an entry is latched and held until accepted
    always_ff @(posedge clk) begin
        if (rst) begin
            ins_busy <= 1'b0;
            ins_idx  <= '0;
        end else if (ins_busy) begin
            if (ins_ready) ins_busy <= 1'b0;
        end else if (cand_any) begin
            ins_busy <= 1'b1;
            ins_idx  <= cand_idx;
        end
    end

    assign ins_valid = ins_busy;
    assign ins_addr  = {eline[ins_idx], OFF_W'(0)};
    assign ins_data  = edata[ins_idx];

endmodule

// File: rtl/sfb_checker.sv
module sfb_checker #(
    parameter int N_ENT  = 8,
    parameter int ADDR_W = 32,
    parameter int LINE_W = 512,
    parameter int OFF_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              ins_valid,
    input logic              ins_ready,
    input logic [ADDR_W-1:0] ins_addr,
    input logic [LINE_W-1:0] ins_data,
    input logic [N_ENT-1:0]  valid_vec,
    input logic [N_ENT-1:0]  pend_vec,
    input logic [N_ENT-1:0]  spec_vec
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'(1) << OFF_W) - 1);

    p_resp_follows_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready) |=> resp_valid);

    p_resp_only_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        !(iss_valid && iss_ready) |=> !resp_valid);

    p_miss_fetches_r2: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> mem_req_valid);

    p_req_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> ((mem_req_addr & LOW_MASK) == '0));

    p_hit_no_fetch_r3: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit) |-> !mem_req_valid);

    p_full_stalls_r5: assert property (@(posedge clk) disable iff (rst)
        ($countones(valid_vec) == N_ENT) |-> !iss_ready);

    p_pend_not_spec_r6: assert property (@(posedge clk) disable iff (rst)
        ((pend_vec & spec_vec) == '0) && ((pend_vec & ~valid_vec) == '0));

    p_ins_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !ins_ready) |=> (ins_valid && $stable(ins_addr) && $stable(ins_data)));

    p_ins_committed_r10: assert property (@(posedge clk) disable iff (rst)
        ins_valid |-> (pend_vec != '0));

endmodule

bind spec_fill_buffer sfb_checker #(
    .N_ENT  (N_ENT),
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W),
    .OFF_W  (OFF_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .iss_valid     (iss_valid),
    .iss_ready     (iss_ready),
    .resp_valid    (resp_valid),
    .resp_hit      (resp_hit),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .ins_valid     (ins_valid),
    .ins_ready     (ins_ready),
    .ins_addr      (ins_addr),
    .ins_data      (ins_data),
    .valid_vec     (valid_vec),
    .pend_vec      (pend_vec),
    .spec_vec      (spec_vec)
);

// File: tb/spec_fill_buffer_tb.sv
`timescale 1ns/1ps
module spec_fill_buffer_tb_top;
    localparam int NE = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         iss_valid, iss_ready;
    logic [3:0]   iss_tag;
    logic [31:0]  iss_addr;
    logic         resp_valid, resp_hit;
    logic [3:0]   resp_tag;
    logic [511:0] resp_data;
    logic         mem_req_valid;
    logic [31:0]  mem_req_addr;
    logic [3:0]   mem_req_tag;
    logic         fill_valid;
    logic [3:0]   fill_tag;
    logic [511:0] fill_data;
    logic         cmt_valid, sq_valid;
    logic [3:0]   cmt_tag, sq_tag;
    logic         ins_valid, ins_ready;
    logic [31:0]  ins_addr;
    logic [511:0] ins_data;

    always #2 clk = ~clk;

    spec_fill_buffer dut_i (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_tag(iss_tag), .iss_addr(iss_addr),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_tag(resp_tag), .resp_data(resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
        .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_data(fill_data),
        .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .sq_valid(sq_valid), .sq_tag(sq_tag),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_addr(ins_addr), .ins_data(ins_data)
    );

    int checks = 0;
    int errors = 0;

    // Behavioural model, indexed by load tag
    bit          m_valid [16];
    bit          m_spec  [16];
    bit          m_pend  [16];
    bit          m_filled[16];
    logic [25:0] m_line  [16];
    int          m_count = 0;
    int          n_commits = 0;
    int          n_installs = 0;

    bit          e_resp_valid, e_hit, e_req;
    logic [3:0]  e_tag;
    logic [25:0] e_line;
    bit          prev_stall = 0;
    logic [31:0] prev_ins_addr;

    function automatic logic [511:0] linedata(input logic [25:0] l);
        logic [511:0] d;
        for (int i = 0; i < 16; i++) d[i*32 +: 32] = {6'b0, l} ^ (32'(i) * 32'h0101_0101) ^ 32'h5A00_0000;
        return d;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model update for the coming edge, then compare after it
    task automatic tick();
        bit acc, hit, found;
        logic [25:0] il;
        acc = iss_valid && (m_count < NE);
        il  = iss_addr[31:6];
        hit = 0;
        for (int t = 0; t < 16; t++) if (m_valid[t] && m_filled[t] && m_line[t] == il) hit = 1;

        if (ins_valid && ins_ready) begin
            found = 0;
            for (int t = 0; t < 16; t++)
                if (!found && m_valid[t] && m_pend[t] && m_filled[t] && m_line[t] == ins_addr[31:6]) begin
                    found = 1; m_valid[t] = 0; m_pend[t] = 0;
                end
            chk(found, "R10 install matches a committed load", {480'b0, ins_addr}, 0);
            chk(ins_data == linedata(ins_addr[31:6]), "R6 install data", ins_data, linedata(ins_addr[31:6]));
            if (found) n_installs++;
        end
        if (prev_stall)
            chk(ins_valid && ins_addr == prev_ins_addr, "R7 install held", {480'b0, ins_addr}, {480'b0, prev_ins_addr});
        prev_stall    = ins_valid && !ins_ready;
        prev_ins_addr = ins_addr;

        if (sq_valid && m_valid[sq_tag] && m_spec[sq_tag]) m_valid[sq_tag] = 0;
        if (cmt_valid && m_valid[cmt_tag] && m_spec[cmt_tag]) begin
            m_spec[cmt_tag] = 0; m_pend[cmt_tag] = 1; n_commits++;
        end
        if (fill_valid && m_valid[fill_tag] && !m_filled[fill_tag]) m_filled[fill_tag] = 1;
        if (acc) begin
            m_valid[iss_tag] = 1; m_spec[iss_tag] = 1; m_pend[iss_tag] = 0;
            m_filled[iss_tag] = hit; m_line[iss_tag] = il;
        end
        e_resp_valid = acc; e_hit = acc && hit; e_req = acc && !hit;
        e_tag = iss_tag; e_line = il;
        m_count = 0;
        for (int t = 0; t < 16; t++) if (m_valid[t]) m_count++;

        @(posedge clk);
        @(negedge clk);
        chk(resp_valid == e_resp_valid, "R2 resp_valid", resp_valid, e_resp_valid);
        if (e_resp_valid) begin
            chk(resp_hit == e_hit && resp_tag == e_tag, "R3 hit/tag", {resp_hit, resp_tag}, {e_hit, e_tag});
            if (e_hit) chk(resp_data == linedata(e_line), "R3 hit data", resp_data, linedata(e_line));
        end
        chk(mem_req_valid == e_req, "R2 mem_req_valid", mem_req_valid, e_req);
        if (e_req)
            chk(mem_req_addr == {e_line, 6'b0} && mem_req_tag == e_tag, "R2 mem_req addr/tag",
                {mem_req_tag, mem_req_addr}, {e_tag, e_line, 6'b0});
        chk(iss_ready == (m_count < NE), "R5 iss_ready", iss_ready, m_count < NE);
        if (ins_valid) begin
            found = 0;
            for (int t = 0; t < 16; t++) if (m_valid[t] && m_pend[t] && m_filled[t]) found = 1;
            chk(found, "R6 install only for committed filled", ins_valid, 0);
        end
    endtask

    task automatic idle();
        iss_valid = 0; fill_valid = 0; cmt_valid = 0; sq_valid = 0;
    endtask

    task automatic do_issue(input logic [3:0] t, input logic [25:0] l);
        idle(); iss_valid = 1; iss_tag = t; iss_addr = {l, 6'(t * 3)}; tick();
    endtask

    task automatic do_fill(input logic [3:0] t, input logic [25:0] l);
        idle(); fill_valid = 1; fill_tag = t; fill_data = linedata(l); tick();
    endtask

    task automatic do_ev(input bit c, input logic [3:0] ct, input bit s, input logic [3:0] st);
        idle(); cmt_valid = c; cmt_tag = ct; sq_valid = s; sq_tag = st; tick();
    endtask

    task automatic drain();
        idle(); ins_ready = 1;
        for (int i = 0; i < 40; i++) tick();
    endtask

    initial begin
        for (int t = 0; t < 16; t++) begin
            m_valid[t] = 0; m_spec[t] = 0; m_pend[t] = 0; m_filled[t] = 0; m_line[t] = '0;
        end
        rst = 1; idle(); iss_tag = 0; iss_addr = 0; fill_tag = 0; fill_data = '0;
        cmt_tag = 0; sq_tag = 0; ins_ready = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk(iss_ready && !resp_valid && !mem_req_valid && !ins_valid, "R1 reset state",
            {iss_ready, resp_valid, mem_req_valid, ins_valid}, 4'b1000);

        // Miss, fill, then hit on the same line
        do_issue(4'd1, 26'h100);
        do_fill(4'd1, 26'h100);
        do_issue(4'd2, 26'h100);
        chk(resp_hit == 1'b1, "R4 fill made line visible", resp_hit, 1);
        // Fill for a tag that holds no entry is ignored
        do_issue(4'd3, 26'h200);
        do_fill(4'd9, 26'h200);
        do_issue(4'd4, 26'h200);
        chk(resp_hit == 1'b0, "R4 stray fill ignored", resp_hit, 0);

        // Commit and squash on the same tag: squash wins
        do_ev(1, 4'd1, 1, 4'd1);
        do_ev(1, 4'd2, 0, 4'd0);
        idle();
        for (int i = 0; i < 6; i++) tick();
        chk(ins_valid == 1'b1, "R7 install waits for ready", ins_valid, 1);
        drain();
        chk(n_installs == 1, "R9 squash beats commit", n_installs, 1);
        do_ev(0, 0, 1, 4'd3);
        do_ev(0, 0, 1, 4'd4);
        do_fill(4'd3, 26'h200);
        do_issue(4'd5, 26'h200);
        chk(resp_hit == 1'b0, "R8 squashed line gone", resp_hit, 0);
        do_ev(0, 0, 1, 4'd5);

        // Fill every entry
        for (int i = 0; i < NE; i++) do_issue(4'(i + 6), 26'h300 + 26'(i));
        chk(iss_ready == 1'b0, "R5 full stalls", iss_ready, 0);
        do_issue(4'd0, 26'h400);
        chk(resp_valid == 1'b0, "R5 stalled issue not taken", resp_valid, 0);
        for (int i = 0; i < NE; i++) do_ev(0, 0, 1, 4'(i + 6));
        chk(iss_ready == 1'b1, "R8 squash frees", iss_ready, 1);

        // Random traffic with colliding events
        for (int n = 0; n < 4000; n++) begin
            int pick;
            idle();
            ins_ready = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 2) == 0) begin
                pick = $urandom_range(0, 15);
                for (int k = 0; k < 16; k++)
                    if (m_valid[(pick + k) % 16]) begin
                        if (!m_filled[(pick + k) % 16] || $urandom_range(0, 1) == 0) begin
                            fill_valid = 1; fill_tag = 4'((pick + k) % 16);
                            fill_data = linedata(m_line[(pick + k) % 16]);
                        end
                        break;
                    end
            end
            if ($urandom_range(0, 1) == 0) begin
                pick = $urandom_range(0, 15);
                for (int k = 0; k < 16; k++)
                    if (!m_valid[(pick + k) % 16]) begin
                        iss_valid = 1; iss_tag = 4'((pick + k) % 16);
                        iss_addr = {26'h500 + 26'($urandom_range(0, 5)), 6'($urandom_range(0, 63))};
                        break;
                    end
            end
            if ($urandom_range(0, 3) == 0) begin
                cmt_valid = 1; cmt_tag = 4'($urandom_range(0, 15));
            end
            if ($urandom_range(0, 5) == 0) begin
                sq_valid = 1; sq_tag = ($urandom_range(0, 2) == 0) ? cmt_tag : 4'($urandom_range(0, 15));
            end
            tick();
        end

        // Retire everything left and drain
        for (int t = 0; t < 16; t++) begin
            if (m_valid[t] && !m_filled[t]) do_fill(4'(t), m_line[t]);
            if (m_valid[t] && m_spec[t]) do_ev(1, 4'(t), 0, 0);
        end
        drain();
        chk(n_installs == n_commits, "R10 installs equal commits", n_installs, n_commits);
        chk(m_count == 0 && iss_ready, "R7 entries freed after install", m_count, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule